// File: doc/BRIEF.md
# Opcode-driven half-duplex SPI command engine

This block is a SPI master that runs one complete command frame each time software sets its execute bit. A frame drives the chosen chip select low, shifts out an opcode byte, then a programmed number of payload bytes taken from a 64-entry byte buffer, and then clocks in a programmed number of response bytes. The response bytes are written into the same buffer, directly behind the payload, so software reads them at the buffer offset that follows its transmitted data.

Software talks to the engine over a small byte-addressable register bus. Every access is either a single byte or an aligned 32-bit word. The control word holds the opcode, a self-clearing execute bit, a self-clearing buffer-pointer clear bit and a read-only busy flag. Separate byte registers hold the payload count, the response count and the chip-select number. The serial side runs in mode 0, MSB first, with the serial clock derived from the system clock by a fixed divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the control word reads 0x00000000, every chip select is high, and the serial clock is low.
- R2: The execute bit (control bit 16) and the pointer-clear bit (control bit 20) always read back as 0. Busy (control bit 31) reads 1 from the first cycle after an accepted execute write until the frame has ended.
- R3: A frame sends on MOSI, MSB first, the opcode (control bits 7:0) and then tx_count bytes read from consecutive buffer entries, starting at the internal buffer pointer.
- R4: Response byte i of a frame that started with the pointer at 0 is readable at bus offset 0x80 + tx_count + i once busy has cleared.
- R5: The chip-select number (bits 1:0 of the byte at offset 0x1D) selects which cs_n line goes low for the frame. Exactly one line is low during a frame, and none is low outside one.
- R6: SCLK idles low. A frame produces exactly 8 × (1 + tx_count + rx_count) rising edges, and consecutive rising edges are 2 × SCLK_HALF system clocks apart.
- R7: An execute write that arrives while busy is set has no effect. No second frame is started and no extra byte appears on MOSI.
- R8: A count of zero skips its phase. With both counts at zero the frame carries only the opcode.
- R9: Without a pointer clear, the next frame continues at the entry that follows the last entry the previous frame used. A clear that is written in the same word as execute takes effect first, so that frame starts at entry 0.
- R10: Buffer accesses past entry 63 are dropped. Payload bytes beyond it are sent as 0x00, and response bytes beyond it are not stored and do not wrap onto entry 0.
- R11: A 32-bit access at an aligned address covers its four byte offsets in little-endian order. The payload count sits at offset 0x48 (word 0x48, bits 7:0), the response count at offset 0x4B (bits 31:24), and the buffer at 0x80 to 0xBF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = aligned 32-bit access, 0 = single byte |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data; byte accesses use bits 7:0 |
| bus_rdata | output | 32 | Combinational read data; byte reads return bits 7:0 |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in, sampled on SCLK rising edges |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Two functions can land in the same cycle: the pointer clear and the frame start, since both come from one control-word write. The bench first runs a frame without a clear, so that the pointer stays parked mid-buffer, and checks that the payload continues from there. It then writes execute and clear in a single word and checks that the first payload byte on MOSI is entry 0, a value it knows from an earlier response. A second collision, execute arriving while a frame is running, is provoked by a back-to-back control write and judged by the MOSI byte stream and the frame count.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Register byte offsets (software-visible layout)
  localparam logic [7:0] OFS_OPCODE = 8'h00;  // control bits 7:0
  localparam logic [7:0] OFS_CMD    = 8'h02;  // control bits 23:16 (exec bit0, clear bit4)
  localparam logic [7:0] OFS_STAT   = 8'h03;  // control bits 31:24 (busy bit7)
  localparam logic [7:0] OFS_CSNUM  = 8'h1D;
  localparam logic [7:0] OFS_TXN    = 8'h48;
  localparam logic [7:0] OFS_RXN    = 8'h4B;
  localparam logic [7:0] OFS_BUF    = 8'h80;

  localparam int CMD_EXEC_BIT  = 0;
  localparam int CMD_CLEAR_BIT = 4;

  typedef enum logic [1:0] {
    PH_OP = 2'd0,
    PH_TX = 2'd1,
    PH_RX = 2'd2
  } phase_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CS_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            lane_we,
  input  logic [LANES-1:0][7:0]       lane_addr,
  input  logic [LANES-1:0][7:0]       lane_wd,
  output logic [LANES-1:0][7:0]       lane_rd,
  input  logic                        eng_busy,
  output logic [7:0]                  opcode,
  output logic [7:0]                  tx_cnt,
  output logic [7:0]                  rx_cnt,
  output logic [CS_W-1:0]             cs_num,
  output logic                        exec_req,
  output logic                        clr_req
);

  logic [7:0]      opc_q, opc_d;
  logic [7:0]      txn_q, txn_d;
  logic [7:0]      rxn_q, rxn_d;
  logic [CS_W-1:0] csn_q, csn_d;
  logic            exec_q, exec_d;
  logic            clr_q, clr_d;
  logic            busy_vis;

  // Busy as seen by software covers the request cycle and the whole frame.
  assign busy_vis = eng_busy | exec_q;

  always_comb begin
    opc_d  = opc_q;
    txn_d  = txn_q;
    rxn_d  = rxn_q;
    csn_d  = csn_q;
    exec_d = 1'b0;
    clr_d  = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) begin
        case (lane_addr[l])
          OFS_OPCODE: opc_d = lane_wd[l];
          OFS_CMD: begin
            if (!busy_vis) begin
              exec_d = lane_wd[l][CMD_EXEC_BIT];
              clr_d  = lane_wd[l][CMD_CLEAR_BIT];
            end
          end
          OFS_CSNUM:  csn_d = lane_wd[l][CS_W-1:0];
          OFS_TXN:    txn_d = lane_wd[l];
          OFS_RXN:    rxn_d = lane_wd[l];
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= '0;
      txn_q  <= '0;
      rxn_q  <= '0;
      csn_q  <= '0;
      exec_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      opc_q  <= opc_d;
      txn_q  <= txn_d;
      rxn_q  <= rxn_d;
      csn_q  <= csn_d;
      exec_q <= exec_d;
      clr_q  <= clr_d;
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      case (lane_addr[l])
        OFS_OPCODE: lane_rd[l] = opc_q;
        OFS_STAT:   lane_rd[l] = {busy_vis, 7'b0};
        OFS_CSNUM:  lane_rd[l] = 8'(csn_q);
        OFS_TXN:    lane_rd[l] = txn_q;
        OFS_RXN:    lane_rd[l] = rxn_q;
        default:    lane_rd[l] = 8'h00;
      endcase
    end
  end

  assign opcode   = opc_q;
  assign tx_cnt   = txn_q;
  assign rx_cnt   = rxn_q;
  assign cs_num   = csn_q;
  assign exec_req = exec_q;
  assign clr_req  = clr_q;

  // R7: a start request never coexists with a running frame
  a_r7_no_req_during_frame: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !exec_q);

  // R2: an accepted request makes the engine busy on the next edge
  a_r2_req_starts_engine: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |=> eng_busy);

endmodule

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int DEPTH = 64,
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic [LANES-1:0]           bus_we,
  input  logic [LANES-1:0][$clog2(DEPTH)-1:0] bus_idx,
  input  logic [LANES-1:0][7:0]      bus_wd,
  output logic [LANES-1:0][7:0]      bus_rd,
  input  logic                       eng_we,
  input  logic [$clog2(DEPTH)-1:0]   eng_widx,
  input  logic [7:0]                 eng_wd,
  input  logic [$clog2(DEPTH)-1:0]   eng_ridx,
  output logic [7:0]                 eng_rd
);

  logic [7:0] mem_q [DEPTH];

  // Engine write is issued last, so it wins a same-entry collision.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (bus_we[l]) mem_q[bus_idx[l]] <= bus_wd[l];
    end
    if (eng_we) mem_q[eng_widx] <= eng_wd;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) bus_rd[l] = mem_q[bus_idx[l]];
  end

  assign eng_rd = mem_q[eng_ridx];

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int SCLK_HALF = 2,
  parameter int NUM_CS    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      clr,
  input  logic [7:0]                opcode,
  input  logic [7:0]                tx_cnt,
  input  logic [7:0]                rx_cnt,
  input  logic [$clog2(NUM_CS)-1:0] cs_num,
  output logic [$clog2(DEPTH)-1:0]  rd_idx,
  input  logic [7:0]                rd_data,
  output logic                      wr_en,
  output logic [$clog2(DEPTH)-1:0]  wr_idx,
  output logic [7:0]                wr_data,
  input  logic                      miso,
  output logic                      sclk,
  output logic                      mosi,
  output logic [NUM_CS-1:0]         cs_n,
  output logic                      busy
);

  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int CS_W = $clog2(NUM_CS);
  localparam int DW   = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  state_e          state_q, state_d;
  phase_e          phase_q, phase_d;
  logic [7:0]      left_q, left_d;
  logic [PW-1:0]   ptr_q, ptr_nx;
  logic [7:0]      txn_q, txn_d;
  logic [7:0]      rxn_q, rxn_d;
  logic [CS_W-1:0] csq_q, csq_d;
  logic [7:0]      sh_q, sh_d;
  logic [7:0]      rxs_q, rxs_d;
  logic [2:0]      bit_q, bit_d;
  logic [DW-1:0]   div_q, div_d;
  logic            sclk_q, sclk_d;

  logic            tick;
  logic            ptr_live;
  logic [PW-1:0]   ptr_inc;
  logic [7:0]      fetch;
  logic            go_tx, go_rx, fin;

  assign tick     = (div_q == DW'(SCLK_HALF - 1));
  assign ptr_live = (ptr_q < PW'(DEPTH));
  assign ptr_inc  = ptr_live ? (ptr_q + 1'b1) : ptr_q;
  assign rd_idx   = ptr_q[AW-1:0];
  assign fetch    = ptr_live ? rd_data : 8'h00;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    left_d  = left_q;
    ptr_nx  = ptr_q;
    txn_d   = txn_q;
    rxn_d   = rxn_q;
    csq_d   = csq_q;
    sh_d    = sh_q;
    rxs_d   = rxs_q;
    bit_d   = bit_q;
    div_d   = div_q;
    sclk_d  = sclk_q;
    wr_en   = 1'b0;
    go_tx   = 1'b0;
    go_rx   = 1'b0;
    fin     = 1'b0;
    if (state_q == ST_IDLE) begin
      sclk_d = 1'b0;
      div_d  = '0;
      bit_d  = '0;
      if (clr) ptr_nx = '0;
      if (start) begin
        state_d = ST_RUN;
        phase_d = PH_OP;
        sh_d    = opcode;
        txn_d   = tx_cnt;
        rxn_d   = rx_cnt;
        csq_d   = cs_num;
      end
    end else begin
      div_d = tick ? '0 : (div_q + 1'b1);
      if (tick) begin
        sclk_d = ~sclk_q;
        if (!sclk_q) begin
          // rising SCLK edge: sample in the receive phase only
          if (phase_q == PH_RX) rxs_d = {rxs_q[6:0], miso};
        end else if (bit_q != 3'd7) begin
          bit_d = bit_q + 1'b1;
          sh_d  = {sh_q[6:0], 1'b0};
        end else begin
          bit_d = '0;
          if (phase_q == PH_RX) begin
            wr_en  = ptr_live;
            ptr_nx = ptr_inc;
          end
          case (phase_q)
            PH_OP: begin
              if (txn_q != 8'd0) begin
                go_tx  = 1'b1;
                left_d = txn_q;
              end else if (rxn_q != 8'd0) go_rx = 1'b1;
              else fin = 1'b1;
            end
            PH_TX: begin
              if (left_q > 8'd1) begin
                go_tx  = 1'b1;
                left_d = left_q - 1'b1;
              end else if (rxn_q != 8'd0) go_rx = 1'b1;
              else fin = 1'b1;
            end
            default: begin
              if (left_q > 8'd1) left_d = left_q - 1'b1;
              else fin = 1'b1;
            end
          endcase
          if (go_tx) begin
            phase_d = PH_TX;
            sh_d    = fetch;
            ptr_nx  = ptr_inc;
          end
          if (go_rx) begin
            phase_d = PH_RX;
            left_d  = rxn_q;
            sh_d    = 8'h00;
          end
          if (fin) state_d = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_OP;
      left_q  <= '0;
      ptr_q   <= '0;
      txn_q   <= '0;
      rxn_q   <= '0;
      csq_q   <= '0;
      sh_q    <= '0;
      rxs_q   <= '0;
      bit_q   <= '0;
      div_q   <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      left_q  <= left_d;
      ptr_q   <= ptr_nx;
      txn_q   <= txn_d;
      rxn_q   <= rxn_d;
      csq_q   <= csq_d;
      sh_q    <= sh_d;
      rxs_q   <= rxs_d;
      bit_q   <= bit_d;
      div_q   <= div_d;
      sclk_q  <= sclk_d;
    end
  end

  assign wr_idx  = ptr_q[AW-1:0];
  assign wr_data = rxs_q;
  assign busy    = (state_q == ST_RUN);
  assign sclk    = sclk_q;
  assign mosi    = busy && (phase_q != PH_RX) && sh_q[7];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csel
    assign cs_n[g] = !(busy && (csq_q == CS_W'(g)));
  end

  // R5: at most one select low, and exactly one while a frame runs
  a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n) && (busy == ($countones(~cs_n) == 1)));

  // R6: serial clock stays low between frames
  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R3: MOSI holds still while SCLK is high (mode 0)
  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R7: a frame only begins from a start request
  a_r7_start_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int SCLK_HALF  = 2,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int LANES = 4;
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int CS_W  = $clog2(NUM_CS);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic [LANES-1:0][7:0]    lane_addr;
  logic [LANES-1:0][7:0]    lane_wd;
  logic [LANES-1:0]         lane_on;
  logic [LANES-1:0]         buf_hit;
  logic [LANES-1:0][AW-1:0] buf_idx;
  logic [LANES-1:0]         buf_we;
  logic [LANES-1:0]         reg_we;
  logic [LANES-1:0][7:0]    buf_rd;
  logic [LANES-1:0][7:0]    reg_rd;
  logic [LANES-1:0][7:0]    lane_rd;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = {bus_addr[7:2], 2'(l)};
      lane_on[l]   = bus_word | (bus_addr[1:0] == 2'(l));
      lane_wd[l]   = bus_word ? bus_wdata[8*l +: 8] : bus_wdata[7:0];
      buf_hit[l]   = ({1'b0, lane_addr[l]} >= {1'b0, OFS_BUF}) &&
                     ({1'b0, lane_addr[l]} < ({1'b0, OFS_BUF} + 9'(FIFO_DEPTH)));
      buf_idx[l]   = AW'(lane_addr[l] - OFS_BUF);
      buf_we[l]    = bus_sel & bus_wr & lane_on[l] & buf_hit[l];
      reg_we[l]    = bus_sel & bus_wr & lane_on[l] & ~buf_hit[l];
      lane_rd[l]   = buf_hit[l] ? buf_rd[l] : reg_rd[l];
    end
  end

  assign bus_rdata = bus_word ? lane_rd : {24'h0, lane_rd[bus_addr[1:0]]};

  logic [7:0]      opcode, tx_cnt, rx_cnt;
  logic [CS_W-1:0] cs_num;
  logic            exec_req, clr_req, eng_busy;
  logic [AW-1:0]   eng_ridx, eng_widx;
  logic [7:0]      eng_rd, eng_wd;
  logic            eng_we;

  spi_cmd_regs #(
    .LANES (LANES),
    .CS_W  (CS_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .lane_we   (reg_we),
    .lane_addr (lane_addr),
    .lane_wd   (lane_wd),
    .lane_rd   (reg_rd),
    .eng_busy  (eng_busy),
    .opcode    (opcode),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .cs_num    (cs_num),
    .exec_req  (exec_req),
    .clr_req   (clr_req)
  );

  spi_cmd_fifo #(
    .DEPTH (FIFO_DEPTH),
    .LANES (LANES)
  ) fifo_i (
    .clk      (clk),
    .bus_we   (buf_we),
    .bus_idx  (buf_idx),
    .bus_wd   (lane_wd),
    .bus_rd   (buf_rd),
    .eng_we   (eng_we),
    .eng_widx (eng_widx),
    .eng_wd   (eng_wd),
    .eng_ridx (eng_ridx),
    .eng_rd   (eng_rd)
  );

  spi_cmd_seq #(
    .DEPTH     (FIFO_DEPTH),
    .SCLK_HALF (SCLK_HALF),
    .NUM_CS    (NUM_CS)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (exec_req),
    .clr     (clr_req),
    .opcode  (opcode),
    .tx_cnt  (tx_cnt),
    .rx_cnt  (rx_cnt),
    .cs_num  (cs_num),
    .rd_idx  (eng_ridx),
    .rd_data (eng_rd),
    .wr_en   (eng_we),
    .wr_idx  (eng_widx),
    .wr_data (eng_wd),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .cs_n    (cs_n),
    .busy    (eng_busy)
  );

endmodule

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;

  localparam int HALF    = 2;
  localparam int RISE_NS = 2 * HALF * 4;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_word;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;

  spi_cmd_engine #(.FIFO_DEPTH(64), .SCLK_HALF(HALF), .NUM_CS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int vectors = 0;
  int fails   = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard + slave model ----------------
  logic [7:0] exp_q[$];
  int         cur_tx = 0;
  logic [7:0] seed = 8'h5A;
  int         bits = 0, rises = 0, frames = 0, bad_period = 0;
  longint     last_rise = 0;
  logic [3:0] last_cs = 4'hF;
  logic [7:0] cap = 8'h00;
  logic       miso_r = 1'b0;
  logic       cs_idle;

  assign cs_idle = &cs_n;
  assign miso    = miso_r;

  function automatic logic [7:0] resp(input int j);
    return 8'(j * 29 + int'(seed));
  endfunction

  always @(posedge sclk or negedge cs_idle) begin
    if (!sclk) begin
      bits = 0; rises = 0; bad_period = 0;
      frames++;
      last_cs = cs_n;
      miso_r = 1'b0;
    end else begin
      int k;
      logic [7:0] r, e;
      if (rises > 0 && ($time - last_rise) != RISE_NS) bad_period++;
      last_rise = $time;
      rises++;
      cap = {cap[6:0], mosi};
      bits++;
      if (bits % 8 == 0) begin
        k = bits / 8 - 1;
        if (k < 1 + cur_tx) begin
          if (exp_q.size() == 0) chk(1'b0, "R3", {24'h0, cap}, 32'hFFFF_FFFF);
          else begin
            e = exp_q.pop_front();
            chk(cap == e, "R3", {24'h0, cap}, {24'h0, e});
          end
        end
      end
      k = bits / 8;
      if (k >= 1 + cur_tx) begin
        r = resp(k - 1 - cur_tx);
        miso_r = r[7 - bits % 8];
      end else miso_r = 1'b0;
    end
  end

  // ---------------- bus driver ----------------
  task automatic wr(input logic [7:0] a, input bit word, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit word, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic launch(input logic [7:0] op, input int tx, input int rx, input bit clr,
                        input bit poke, input logic [3:0] cs_exp);
    int f0;
    int n;
    logic [31:0] d;
    cur_tx = tx;
    f0 = frames;
    wr(8'h48, 1'b1, {8'(rx), 16'h0, 8'(tx)});
    wr(8'h00, 1'b1, {11'h0, clr, 3'h0, 1'b1, 8'h0, op});
    if (poke) wr(8'h00, 1'b1, 32'h0001_00C3);
    rd(8'h00, 1'b1, d);
    chk(d[31] && !d[16] && !d[20], "R2", d, 32'h8000_0000);
    n = 0;
    do begin
      rd(8'h00, 1'b1, d);
      n++;
    end while (d[31] && n < 20000);
    chk(!d[31], "R2", d, 32'h0);
    chk(frames == f0 + 1, "R7", frames, f0 + 1);
    chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
    chk(rises == 8 * (1 + tx + rx), "R6", rises, 8 * (1 + tx + rx));
    chk(bad_period == 0, "R6", bad_period, 0);
    chk(last_cs == cs_exp, "R5", {28'h0, last_cs}, {28'h0, cs_exp});
    chk(cs_n == 4'hF && !sclk, "R5", {27'h0, sclk, cs_n}, 32'h0000_000F);
  endtask

  function automatic logic [7:0] fill(input int i);
    return 8'(i * 7 + 1);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [31:0] d;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    rd(8'h00, 1'b1, d);
    chk(d == 32'h0, "R1", d, 32'h0);
    chk(cs_n == 4'hF && !sclk, "R1", {27'h0, sclk, cs_n}, 32'h0000_000F);

    // R11: word and byte register access
    wr(8'h1D, 1'b0, 32'h1);
    rd(8'h1D, 1'b0, d);
    chk(d == 32'h1, "R5", d, 32'h1);
    wr(8'h80, 1'b1, 32'h4433_2211);
    wr(8'h84, 1'b0, 32'h55);
    rd(8'h80, 1'b1, d);
    chk(d == 32'h4433_2211, "R11", d, 32'h4433_2211);
    rd(8'h82, 1'b0, d);
    chk(d == 32'h33, "R11", d, 32'h33);
    wr(8'h48, 1'b1, 32'h0200_0005);
    rd(8'h4B, 1'b0, d);
    chk(d == 32'h2, "R11", d, 32'h2);
    rd(8'h48, 1'b0, d);
    chk(d == 32'h5, "R11", d, 32'h5);

    // R3/R4: opcode + 5 payload bytes + 2 response bytes on select 1
    exp_q = '{8'h9F, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    launch(8'h9F, 5, 2, 1'b1, 1'b0, 4'b1101);
    rd(8'h85, 1'b0, d);
    chk(d[7:0] == resp(0), "R4", d, {24'h0, resp(0)});
    rd(8'h86, 1'b0, d);
    chk(d[7:0] == resp(1), "R4", d, {24'h0, resp(1)});

    // R7 + R8: opcode-only frame, second execute while busy
    wr(8'h1D, 1'b0, 32'h2);
    exp_q = '{8'hA5};
    launch(8'hA5, 0, 0, 1'b1, 1'b1, 4'b1011);

    // R8: receive-only frame on select 3
    wr(8'h1D, 1'b0, 32'h3);
    exp_q = '{8'h03};
    launch(8'h03, 0, 3, 1'b1, 1'b0, 4'b0111);
    for (int i = 0; i < 3; i++) begin
      rd(8'(8'h80 + i), 1'b0, d);
      chk(d[7:0] == resp(i), "R8", d, {24'h0, resp(i)});
    end

    // R9: no clear -> pointer continues at entry 3
    wr(8'h1D, 1'b0, 32'h0);
    wr(8'h83, 1'b0, 32'hC4);
    wr(8'h84, 1'b0, 32'hD5);
    exp_q = '{8'h0B, 8'hC4, 8'hD5};
    launch(8'h0B, 2, 0, 1'b0, 1'b0, 4'b1110);

    // R9: clear written together with execute -> starts at entry 0
    exp_q = '{8'h3B, resp(0)};
    launch(8'h3B, 1, 0, 1'b1, 1'b0, 4'b1110);

    // R10: payload + response exceed the buffer
    for (int w = 0; w < 16; w++)
      wr(8'(8'h80 + 4 * w), 1'b1, {fill(4*w+3), fill(4*w+2), fill(4*w+1), fill(4*w)});
    exp_q.delete();
    exp_q.push_back(8'h6C);
    for (int i = 0; i < 62; i++) exp_q.push_back(fill(i));
    launch(8'h6C, 62, 4, 1'b1, 1'b0, 4'b1110);
    rd(8'hBE, 1'b0, d);
    chk(d[7:0] == resp(0), "R10", d, {24'h0, resp(0)});
    rd(8'hBF, 1'b0, d);
    chk(d[7:0] == resp(1), "R10", d, {24'h0, resp(1)});
    rd(8'h80, 1'b0, d);
    chk(d[7:0] == fill(0), "R10", d, {24'h0, fill(0)});
    rd(8'h81, 1'b0, d);
    chk(d[7:0] == fill(1), "R10", d, {24'h0, fill(1)});

    // R10: payload reads past entry 63 send zeros
    exp_q.delete();
    exp_q.push_back(8'h7E);
    for (int i = 0; i < 62; i++) exp_q.push_back(fill(i));
    exp_q.push_back(resp(0));
    exp_q.push_back(resp(1));
    exp_q.push_back(8'h00);
    exp_q.push_back(8'h00);
    launch(8'h7E, 66, 0, 1'b1, 1'b0, 4'b1110);

    summary();
  end

endmodule